// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block is the transmit half of an asynchronous serial port. Software-side logic writes bytes into a data slot. The bytes queue in a small transmit FIFO and are moved one at a time into a shift register. The shift register drives the serial line. Each character goes out as a low start bit, the configured number of data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Every bit time lasts 16 pulses of an external oversampling enable, so the block never divides the clock itself.

Two status flags are kept apart. The holding-empty flag reports that the FIFO holds nothing more to send, and it can be high while a character is still on the line. The transmitter-empty flag is high only when the FIFO is empty and the shifter is idle. A pending holding-empty event drives an interrupt request when the enable input is high. The pending event is cleared by a read of the interrupt identification register, or by the next accepted data write.

Top module: `serial_tx_queue`

## Requirements
- R1: The line idles high. A frame is a low start bit, then data bits least significant first, then an optional parity bit, then one or two high stop bits. Each bit holds for exactly 16 `baudTick` pulses.
- R2: Mode bits [1:0] select the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Byte bits at or above the length are never sent. The reset value is 8 bits.
- R3: Mode bits [5:3] select parity. 000 means no parity bit. 001 is odd and 011 is even, both counted over the sent data bits only. 101 sends a constant 1 and 111 sends a constant 0. Any value with bit 3 clear means no parity bit. The reset value is none.
- R4: Mode bit [2] selects two stop bits when 1 and one stop bit when 0. The reset value is one.
- R5: When the FIFO holds data and no frame is in progress, the start bit begins on the next clock, well inside 16 baud ticks. When a frame ends with data queued, the next start bit follows with no idle bit.
- R6: `thre` is 1 exactly when the FIFO is empty. It goes low on the clock after an accepted data write. It goes high on the clock that removes the last byte into the shifter.
- R7: `temt` is 1 only when the FIFO is empty and no frame is being shifted. `thre` can be 1 while `temt` is 0.
- R8: A pending holding-empty event is set on the clock that empties the FIFO, unless a write is accepted in that same cycle. `irq` is high while the event is pending and `intEnable` is 1.
- R9: The pending event is cleared by an `iirRead` pulse or by an accepted data write. A set in the same cycle takes priority over a clear from `iirRead`.
- R10: The FIFO holds 16 bytes. A data write while it is full is dropped, and it sets the sticky `ovfSticky` flag, which is cleared only by reset.
- R11: A mode write (`wrAddr`=1, bits [5:0]) takes effect only when the FIFO is empty and no frame is in progress. Otherwise the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baudTick | input | 1 | Enable pulse at 16 times the bit rate |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | Write target: 0 is the data FIFO, 1 is the mode register |
| wrData | input | 8 | Write data |
| intEnable | input | 1 | Holding-empty interrupt enable |
| iirRead | input | 1 | Pulse marking a read of the interrupt identification register |
| txOut | output | 1 | Serial output line |
| thre | output | 1 | FIFO-empty (holding-empty) flag |
| temt | output | 1 | FIFO and shifter both empty |
| irq | output | 1 | Interrupt request |
| ovfSticky | output | 1 | Sticky overflow flag for a write to a full FIFO |

## Verification
On every cycle, the assertions check these properties: the line stays high outside a frame, `temt` never rises without `thre`, a queued byte never waits 16 ticks for its start bit, a write into an empty FIFO drops `thre`, a read of the identification register drops the request, and overflow stays set. The exact bit sequence on the line needs the bench's behavioural model, which is compared with the outputs on every clock. That covers each length, parity and stop setting, MSB truncation, back-to-back frames after a burst, dropped writes to a full FIFO, and a mode write that arrives mid-transfer and must be ignored.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int BYTE_W = 8;
  localparam int OVS    = 16;
  localparam int TICK_W = $clog2(OVS);
  localparam int LEN_MIN = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } frameState_t;

  // parity[0]: enable, parity[1]: even / stick-zero, parity[2]: stick
  typedef struct packed {
    logic [2:0] parity;
    logic       twoStop;
    logic [1:0] lenCode;
  } txMode_t;

  typedef struct packed {
    logic popLoad;
    logic shiftOut;
  } txStrobe_t;

  localparam txMode_t MODE_RESET = '{parity: 3'b000, twoStop: 1'b0, lenCode: 2'b11};
endpackage

// File: rtl/stx_datapath.sv
module stx_datapath
  import stx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  txStrobe_t         strobe,
  input  logic              frameActive,
  output logic              fifoEmpty,
  output logic              lastEntry,
  output logic              pushOk,
  output txMode_t           modeQ,
  output logic              serialBit,
  output logic              parityBit,
  output logic              ovfSticky
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              pop;
  logic [BYTE_W-1:0] keepBits;
  logic [BYTE_W-1:0] shiftReg;
  logic              sentOnes;
  logic              parNext;

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign fifoEmpty = (count == '0);
  assign lastEntry = (count == CNT_W'(1));
  assign pushOk    = wrEn && !wrAddr && !full;
  assign pop       = strobe.popLoad;

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= stepPtr(wrPtr);
      if (pop)    rdPtr <= stepPtr(rdPtr);
      case ({pushOk, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovfSticky <= 1'b0;
      modeQ     <= MODE_RESET;
    end else begin
      if (wrEn && !wrAddr && full) ovfSticky <= 1'b1;
      if (wrEn && wrAddr && !frameActive && fifoEmpty) modeQ <= txMode_t'(wrData[5:0]);
    end
  end

  // mask off bits above the configured length
  generate
    for (genvar i = 0; i < BYTE_W; i++) begin : g_keep
      assign keepBits[i] = mem[rdPtr][i] && (i < (int'(modeQ.lenCode) + LEN_MIN));
    end
  endgenerate

  always_comb begin
    sentOnes = ^keepBits;
    if (modeQ.parity[2])      parNext = !modeQ.parity[1];
    else if (modeQ.parity[1]) parNext = sentOnes;
    else                      parNext = !sentOnes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      parityBit <= 1'b0;
    end else if (pop) begin
      shiftReg  <= keepBits;
      parityBit <= parNext;
    end else if (strobe.shiftOut) begin
      shiftReg  <= shiftReg >> 1;
    end
  end

  assign serialBit = shiftReg[0];
endmodule

// File: rtl/stx_control.sv
module stx_control
  import stx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      baudTick,
  input  logic      fifoEmpty,
  input  logic      lastEntry,
  input  logic      pushOk,
  input  txMode_t   modeQ,
  input  logic      serialBit,
  input  logic      parityBit,
  input  logic      iirRead,
  input  logic      intEnable,
  output txStrobe_t strobe,
  output logic      txOut,
  output logic      frameActive,
  output logic      irq
);
  frameState_t       state, stateNx;
  logic [TICK_W-1:0] tickCnt;
  logic [2:0]        bitCnt, bitCntNx;
  logic              stopCnt, stopCntNx;
  logic              pend;
  logic              bitEnd;
  logic              lastData;

  assign bitEnd   = baudTick && (tickCnt == TICK_W'(OVS - 1));
  assign lastData = (bitCnt == ({1'b0, modeQ.lenCode} + 3'(LEN_MIN - 1)));

  always_comb begin
    stateNx   = state;
    bitCntNx  = bitCnt;
    stopCntNx = stopCnt;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (!fifoEmpty) begin
          strobe.popLoad = 1'b1;
          stateNx        = ST_START;
        end
      end
      ST_START: begin
        if (bitEnd) begin
          stateNx  = ST_DATA;
          bitCntNx = '0;
        end
      end
      ST_DATA: begin
        if (bitEnd) begin
          strobe.shiftOut = 1'b1;
          if (lastData) begin
            stateNx   = modeQ.parity[0] ? ST_PAR : ST_STOP;
            stopCntNx = 1'b0;
          end else begin
            bitCntNx = bitCnt + 1'b1;
          end
        end
      end
      ST_PAR: begin
        if (bitEnd) begin
          stateNx   = ST_STOP;
          stopCntNx = 1'b0;
        end
      end
      ST_STOP: begin
        if (bitEnd) begin
          if (modeQ.twoStop && !stopCnt) begin
            stopCntNx = 1'b1;
          end else if (!fifoEmpty) begin
            strobe.popLoad = 1'b1;
            stateNx        = ST_START;
          end else begin
            stateNx = ST_IDLE;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
      stopCnt <= 1'b0;
      pend    <= 1'b0;
    end else begin
      state   <= stateNx;
      bitCnt  <= bitCntNx;
      stopCnt <= stopCntNx;
      if (state == ST_IDLE) tickCnt <= '0;
      else if (baudTick)    tickCnt <= tickCnt + 1'b1;
      if (strobe.popLoad && lastEntry && !pushOk) pend <= 1'b1;
      else if (pushOk || iirRead)                 pend <= 1'b0;
    end
  end

  always_comb begin
    case (state)
      ST_START: txOut = 1'b0;
      ST_DATA:  txOut = serialBit;
      ST_PAR:   txOut = parityBit;
      default:  txOut = 1'b1;
    endcase
  end

  assign frameActive = (state != ST_IDLE);
  assign irq         = pend && intEnable;
endmodule

// File: rtl/serial_tx_queue.sv
module serial_tx_queue
  import stx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baudTick,
  input  logic       wrEn,
  input  logic       wrAddr,
  input  logic [7:0] wrData,
  input  logic       intEnable,
  input  logic       iirRead,
  output logic       txOut,
  output logic       thre,
  output logic       temt,
  output logic       irq,
  output logic       ovfSticky
);
  txStrobe_t strobe;
  txMode_t   modeQ;
  logic      fifoEmpty, lastEntry, pushOk;
  logic      serialBit, parityBit, frameActive;

  stx_datapath #(.DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .strobe(strobe), .frameActive(frameActive), .fifoEmpty(fifoEmpty),
    .lastEntry(lastEntry), .pushOk(pushOk), .modeQ(modeQ),
    .serialBit(serialBit), .parityBit(parityBit), .ovfSticky(ovfSticky)
  );

  stx_control u_ctl (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .fifoEmpty(fifoEmpty),
    .lastEntry(lastEntry), .pushOk(pushOk), .modeQ(modeQ),
    .serialBit(serialBit), .parityBit(parityBit), .iirRead(iirRead),
    .intEnable(intEnable), .strobe(strobe), .txOut(txOut),
    .frameActive(frameActive), .irq(irq)
  );

  assign thre = fifoEmpty;
  assign temt = fifoEmpty && !frameActive;
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic rst_n,
  input logic baudTick,
  input logic wrEn,
  input logic wrAddr,
  input logic intEnable,
  input logic iirRead,
  input logic txOut,
  input logic thre,
  input logic temt,
  input logic irq,
  input logic ovfSticky,
  input logic frameActive
);
  logic [4:0] waitTicks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     waitTicks <= '0;
    else if (frameActive || thre)   waitTicks <= '0;
    else if (baudTick)              waitTicks <= waitTicks + 1'b1;
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !frameActive |-> txOut);                                    // R1
  AST_PROMPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    waitTicks < 5'd16);                                         // R5
  AST_WRITE_DROPS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !wrAddr && thre) |=> !thre);                       // R6
  AST_TEMT_NEEDS_THRE: assert property (@(posedge clk) disable iff (!rst_n)
    temt |-> thre);                                             // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> intEnable);                                         // R8
  AST_IIR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iirRead && thre) |=> !irq);                                // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovfSticky |=> ovfSticky);                                   // R10
endmodule

bind serial_tx_queue stx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .wrEn(wrEn), .wrAddr(wrAddr),
  .intEnable(intEnable), .iirRead(iirRead), .txOut(txOut), .thre(thre),
  .temt(temt), .irq(irq), .ovfSticky(ovfSticky), .frameActive(frameActive)
);

// File: tb/test_serial_tx_queue.sv
module test_serial_tx_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baudTick = 1'b0;
  logic wrEn = 1'b0, wrAddr = 1'b0, intEnable = 1'b0, iirRead = 1'b0;
  logic [7:0] wrData = '0;
  logic txOut, thre, temt, irq, ovfSticky;

  int total = 0, bad = 0;
  bit started = 0, tickOn = 0;
  string curTag = "R1";

  serial_tx_queue i_serial_tx_queue (
    .clk(clk), .rst_n(rst_n), .baudTick(baudTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .intEnable(intEnable), .iirRead(iirRead), .txOut(txOut),
    .thre(thre), .temt(temt), .irq(irq), .ovfSticky(ovfSticky)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [7:0] mq[$];
  bit mBits[$];
  bit mActive, mPend, mOvf;
  int mPos, mTcnt, sz;
  logic [5:0] mMode;
  bit pushAcc, popped;

  task automatic buildFrame(input logic [7:0] d);
    int len; bit ones; bit pb;
    mBits.delete();
    mBits.push_back(1'b0);
    len = 5 + int'(mMode[1:0]);
    ones = 0;
    for (int i = 0; i < len; i++) begin
      mBits.push_back(d[i]);
      ones ^= d[i];
    end
    if (mMode[3]) begin
      if (mMode[5]) pb = !mMode[4];
      else if (mMode[4]) pb = ones;
      else pb = !ones;
      mBits.push_back(pb);
    end
    mBits.push_back(1'b1);
    if (mMode[2]) mBits.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mActive = 0; mPos = 0; mTcnt = 0; mMode = 6'b000011; mPend = 0; mOvf = 0;
    end else begin
      sz = mq.size();
      popped = 0;
      pushAcc = wrEn && !wrAddr && (sz < DEPTH);
      if (wrEn && !wrAddr && sz >= DEPTH) mOvf = 1;
      if (wrEn && wrAddr && !mActive && sz == 0) mMode = wrData[5:0];
      if (mActive && baudTick) begin
        mTcnt++;
        if (mTcnt == 16) begin
          mTcnt = 0;
          mPos++;
          if (mPos == mBits.size()) mActive = 0;
        end
      end
      if (!mActive && sz > 0) begin
        buildFrame(mq.pop_front());
        mActive = 1; mPos = 0; mTcnt = 0; popped = 1;
      end
      if (pushAcc) mq.push_back(wrData);
      if (pushAcc || iirRead) mPend = 0;
      if (popped && sz == 1 && !pushAcc) mPend = 1;
    end
  end

  function automatic bit mTx();
    return mActive ? mBits[mPos] : 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && started) begin
      chk(txOut === mTx(), curTag, int'(txOut), int'(mTx()));
      chk(thre === (mq.size() == 0), "R6", int'(thre), int'(mq.size() == 0));
      chk(temt === (mq.size() == 0 && !mActive), "R7", int'(temt), int'(mq.size() == 0 && !mActive));
      chk(irq === (mPend && intEnable), "R8", int'(irq), int'(mPend && intEnable));
      chk(ovfSticky === mOvf, "R10", int'(ovfSticky), int'(mOvf));
    end
  end

  initial begin : tickGen
    forever begin
      @(negedge clk);
      baudTick = tickOn && (($urandom % 4) != 0);
    end
  end

  task automatic wrByte(input logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = 0; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic wrMode(input logic [5:0] m);
    @(negedge clk); wrEn = 1; wrAddr = 1; wrData = {2'b00, m};
    @(negedge clk); wrEn = 0; wrAddr = 0;
  endtask

  task automatic pulseIir();
    @(negedge clk); iirRead = 1;
    @(negedge clk); iirRead = 0;
  endtask

  task automatic waitIdle();
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (mq.size() == 0 && !mActive) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #2;
    chk(txOut === 1'b1, "R1", int'(txOut), 1);
    chk(thre === 1'b1, "R6", int'(thre), 1);
    chk(temt === 1'b1, "R7", int'(temt), 1);
    chk(irq === 1'b0, "R8", int'(irq), 0);
    chk(ovfSticky === 1'b0, "R10", int'(ovfSticky), 0);
    started = 1; tickOn = 1;

    // 8N1 default, prompt start, THRE without TEMT, interrupt raise
    curTag = "R1";
    intEnable = 1;
    wrByte(8'hA5);
    #2 chk(thre === 1'b0, "R6", int'(thre), 0);
    @(negedge clk); #2;
    chk(txOut === 1'b0, "R5", int'(txOut), 0);
    chk(thre === 1'b1 && temt === 1'b0, "R7", int'(temt), 0);
    chk(irq === 1'b1, "R8", int'(irq), 1);
    pulseIir();
    #2 chk(irq === 1'b0, "R9", int'(irq), 0);
    waitIdle();

    // write clears pending event
    wrByte(8'h3C);
    @(negedge clk); #2 chk(irq === 1'b1, "R8", int'(irq), 1);
    wrByte(8'h11);
    #2 chk(irq === 1'b0, "R9", int'(irq), 0);
    waitIdle();

    // 7-bit, even parity, two stops: MSB dropped
    curTag = "R2";
    wrMode(6'b011110);
    wrByte(8'hC5);
    wrByte(8'h80);
    waitIdle();

    // 5-bit odd parity
    curTag = "R3";
    wrMode(6'b001000);
    wrByte(8'h1F);
    wrByte(8'hE0);
    waitIdle();

    // 6-bit stick-1, two stops
    curTag = "R4";
    wrMode(6'b101101);
    wrByte(8'h2A);
    waitIdle();

    // 8-bit stick-0, one stop
    curTag = "R3";
    wrMode(6'b111011);
    wrByte(8'hFF);
    waitIdle();

    // burst overflow and back-to-back frames, mode write while busy ignored
    curTag = "R11";
    wrMode(6'b000011);
    intEnable = 0;
    for (int i = 0; i < 20; i++) wrByte(8'(i * 13 + 7));
    #2 chk(ovfSticky === 1'b1, "R10", int'(ovfSticky), 1);
    wrMode(6'b001000);
    #2 chk(thre === 1'b0, "R11", int'(thre), 0);
    waitIdle();
    chk(ovfSticky === 1'b1, "R10", int'(ovfSticky), 1);

    // confirm 8N1 still in force after ignored write
    wrByte(8'h96);
    waitIdle();

    started = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule